// File: doc/BRIEF.md
# Two-Level Set/Clear/Mask Interrupt Aggregator

This block collects interrupt requests into a single output line. A 32-bit top-level pending word holds direct sources, set or cleared by software writes or by hardware event inputs. Two sub-level groups, a USB-core group and a DMA group, each hold their own 32-bit pending and mask words. Each group folds into reserved summary bits of the top-level word, so software can trace a top-level request down to its sub-level source.

Every group has three write addresses: one ORs data into its pending word, one clears the pending bits that are 1 in the data, and one loads its mask. A configuration word picks the polarity of the output line. A power-up hold-off gate keeps the line low from the moment power is applied until a programmable number of cycles has passed with power still present.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the top-level mask reads 0xFFFFFFFF. All pending words, both sub-level masks and the configuration word read 0, and irq_o is low.
- R2: A write to a group's SET address ORs wdata_i into that group's pending word. A write to its CLEAR address clears every pending bit that is 1 in wdata_i. A write to its MASK address loads the mask.
- R3: The byte addresses are, top group: SRC 0x00, SET 0x04, CLEAR 0x08, MASK 0x0C; USB-core group: 0x10, 0x14, 0x18, 0x1C; DMA group: 0x20, 0x24, 0x28, 0x2C; configuration: 0x30. Reads of a group's SRC, SET and CLEAR addresses all return its pending word, and its MASK address returns its mask.
- R4: One cycle after a USB-core change, top bit 9 is 1 exactly when an unmasked USB-core pending bit lies in bits 15:0, and top bit 8 is 1 exactly when one lies in bits 31:16.
- R5: One cycle after a DMA change, top bit 24 is 1 exactly when any unmasked DMA pending bit exists.
- R6: Summary bits 24, 9 and 8 are not changed by top-level SET or CLEAR writes or by hardware event inputs.
- R7: A 1 on hw_set_i sets that top bit in the next cycle. A 1 on hw_clr_i clears it. A hardware set beats any clear, software or hardware, in the same cycle.
- R8: With configuration bit 17 set, the line is high when any unmasked top-level bit is pending. With bit 17 clear, the line is high only when none is pending.
- R9: irq_o is a register, recomputed every cycle from the current pending word, mask, polarity and gate.
- R10: A rising edge on power_i forces irq_o low. The gate opens HOLD_CYC cycles after that edge, but only if power_i stays high throughout. If power_i drops during that time, the gate stays closed until the next rising edge has run its full count.
- R11: Writes to unmapped addresses change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| power_i | input | 1 | Power-present level; a rising edge restarts the hold-off |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i (combinational) |
| hw_set_i | input | DW | Hardware set request per top-level bit |
| hw_clr_i | input | DW | Hardware clear request per top-level bit |
| irq_o | output | 1 | Interrupt line |

## Verification
One pending bit at a time is walked across all 32 positions of the USB-core group and of the DMA group, with that bit first unmasked and then masked. This shows whether the half-word split feeds bits 9 and 8 correctly, and whether a sub-level mask blocks a bit. Every non-summary top-level bit is walked with its top mask set and then clear, under both polarities. This separates a masking fault from a polarity fault. Software writes to the summary bits, and a hardware set colliding with a software or hardware clear, cover the corner cases. A power pulse cut off partway through the hold-off is also tried, and it must leave the line low.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned TX_SUM_BIT  = 9;
  localparam int unsigned RX_SUM_BIT  = 8;
  localparam int unsigned DMA_SUM_BIT = 24;
  localparam int unsigned POL_BIT     = 17;

  typedef enum logic [3:0] {
    IDX_TOP_SRC  = 4'd0,  IDX_TOP_SET  = 4'd1,  IDX_TOP_CLR  = 4'd2,  IDX_TOP_MSK  = 4'd3,
    IDX_CORE_SRC = 4'd4,  IDX_CORE_SET = 4'd5,  IDX_CORE_CLR = 4'd6,  IDX_CORE_MSK = 4'd7,
    IDX_DMA_SRC  = 4'd8,  IDX_DMA_SET  = 4'd9,  IDX_DMA_CLR  = 4'd10, IDX_DMA_MSK  = 4'd11,
    IDX_CFG      = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/irq_sub_group.sv
module irq_sub_group #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_we_i,
  input  logic          clr_we_i,
  input  logic          msk_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] pend_o,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] set_v, clr_v;
  assign set_v = set_we_i ? wdata_i : '0;
  assign clr_v = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      mask_o <= '0;
    end else begin
      pend_o <= (pend_o | set_v) & ~clr_v;
      if (msk_we_i) mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_top_word.sv
module irq_top_word
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic [W-1:0] core_pend_i,
  input  logic [W-1:0] core_mask_i,
  input  logic [W-1:0] dma_pend_i,
  input  logic [W-1:0] dma_mask_i,
  output logic [W-1:0] word_o,
  output logic [W-1:0] mask_o
);
  localparam int unsigned HALF = W / 2;
  localparam logic [W-1:0] SUM_M = (W'(1) << TX_SUM_BIT) | (W'(1) << RX_SUM_BIT) |
                                   (W'(1) << DMA_SUM_BIT);

  logic [W-1:0] stored_q, set_v, clr_v, core_act, dma_act;
  logic         tx_q, rx_q, dma_q;

  assign set_v    = set_we_i ? wdata_i : '0;
  assign clr_v    = clr_we_i ? wdata_i : '0;
  assign core_act = core_pend_i & ~core_mask_i;
  assign dma_act  = dma_pend_i & ~dma_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
      mask_o   <= '1;
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      // hardware set wins over every clear
      stored_q <= ((((stored_q | set_v) & ~(clr_v | hw_clr_i)) | hw_set_i)) & ~SUM_M;
      if (msk_we_i) mask_o <= wdata_i;
      tx_q  <= |core_act[HALF-1:0];
      rx_q  <= |core_act[W-1:HALF];
      dma_q <= |dma_act;
    end
  end

  always_comb begin
    word_o = stored_q;
    word_o[TX_SUM_BIT]  = tx_q;
    word_o[RX_SUM_BIT]  = rx_q;
    word_o[DMA_SUM_BIT] = dma_q;
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int unsigned HOLD_CYC = 30000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic power_i,
  output logic gate_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic          pwr_q, run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      gate_o <= 1'b0;
    end else begin
      pwr_q <= power_i;
      if (power_i && !pwr_q) begin
        gate_o <= 1'b0;
        run_q  <= 1'b1;
        cnt_q  <= CW'(HOLD_CYC);
      end else if (run_q) begin
        if (!power_i) begin
          run_q <= 1'b0;
        end else if (cnt_q <= CW'(1)) begin
          run_q  <= 1'b0;
          gate_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned HOLD_CYC = 30000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              power_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     hw_set_i,
  input  logic [DW-1:0]     hw_clr_i,
  output logic              irq_o
);
  localparam int unsigned NSUB = 2;

  logic [3:0]    widx;
  logic [DW-1:0] sub_pend [NSUB];
  logic [DW-1:0] sub_mask [NSUB];
  logic [DW-1:0] top_word, top_mask;
  logic          pol_q, gate, any_act;

  assign widx = (addr_i[ADDR_W-1:6] == '0) ? addr_i[5:2] : 4'hf;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    localparam logic [3:0] BASE = 4'(4 * (g + 1));
    irq_sub_group #(.DW(DW)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_we_i(wr_en_i && widx == BASE + 4'd1),
      .clr_we_i(wr_en_i && widx == BASE + 4'd2),
      .msk_we_i(wr_en_i && widx == BASE + 4'd3),
      .wdata_i (wdata_i),
      .pend_o  (sub_pend[g]),
      .mask_o  (sub_mask[g])
    );
  end

  irq_top_word #(.W(DW)) u_top (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_we_i   (wr_en_i && widx == IDX_TOP_SET),
    .clr_we_i   (wr_en_i && widx == IDX_TOP_CLR),
    .msk_we_i   (wr_en_i && widx == IDX_TOP_MSK),
    .wdata_i    (wdata_i),
    .hw_set_i   (hw_set_i),
    .hw_clr_i   (hw_clr_i),
    .core_pend_i(sub_pend[0]),
    .core_mask_i(sub_mask[0]),
    .dma_pend_i (sub_pend[1]),
    .dma_mask_i (sub_mask[1]),
    .word_o     (top_word),
    .mask_o     (top_mask)
  );

  irq_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .power_i(power_i),
    .gate_o (gate)
  );

  assign any_act = |(top_word & ~top_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en_i && widx == IDX_CFG) pol_q <= wdata_i[POL_BIT];
      irq_o <= gate & (pol_q ? any_act : ~any_act);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      IDX_TOP_SRC, IDX_TOP_SET, IDX_TOP_CLR:    rdata_o = top_word;
      IDX_TOP_MSK:                              rdata_o = top_mask;
      IDX_CORE_SRC, IDX_CORE_SET, IDX_CORE_CLR: rdata_o = sub_pend[0];
      IDX_CORE_MSK:                             rdata_o = sub_mask[0];
      IDX_DMA_SRC, IDX_DMA_SET, IDX_DMA_CLR:    rdata_o = sub_pend[1];
      IDX_DMA_MSK:                              rdata_o = sub_mask[1];
      IDX_CFG:                                  rdata_o[POL_BIT] = pol_q;
      default:                                  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              power_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     hw_set_i,
  input logic [DW-1:0]     core_pend,
  input logic [DW-1:0]     core_mask,
  input logic [DW-1:0]     dma_pend,
  input logic [DW-1:0]     dma_mask,
  input logic [DW-1:0]     top_word,
  input logic [DW-1:0]     top_mask,
  input logic              gate,
  input logic              pol,
  input logic              irq_o
);
  localparam logic [DW-1:0] SUM_M = (DW'(1) << TX_SUM_BIT) | (DW'(1) << RX_SUM_BIT) |
                                    (DW'(1) << DMA_SUM_BIT);
  logic core_wr_set, core_wr_clr;
  assign core_wr_set = wr_en_i && addr_i == ADDR_W'(4 * IDX_CORE_SET);
  assign core_wr_clr = wr_en_i && addr_i == ADDR_W'(4 * IDX_CORE_CLR);

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_set |=> (core_pend & $past(wdata_i)) == $past(wdata_i));
  p_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_clr |=> (core_pend & $past(wdata_i)) == '0);
  p_tx_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> top_word[TX_SUM_BIT] == $past(|(core_pend[DW/2-1:0] & ~core_mask[DW/2-1:0])));
  p_dma_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> top_word[DMA_SUM_BIT] == $past(|(dma_pend & ~dma_mask)));
  p_hw_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i & ~SUM_M) != '0 |=> (top_word & $past(hw_set_i & ~SUM_M)) == $past(hw_set_i & ~SUM_M));
  p_pol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && pol && (top_word & ~top_mask) != '0) |=> irq_o);
  p_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate |=> !irq_o);
  p_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(power_i) |=> !gate);
endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .power_i  (power_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .hw_set_i (hw_set_i),
  .core_pend(sub_pend[0]),
  .core_mask(sub_mask[0]),
  .dma_pend (sub_pend[1]),
  .dma_mask (sub_mask[1]),
  .top_word (top_word),
  .top_mask (top_mask),
  .gate     (gate),
  .pol      (pol_q),
  .irq_o    (irq_o)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int HOLD = 16;
  localparam logic [31:0] SUMS = (32'd1 << 24) | (32'd1 << 9) | (32'd1 << 8);
  localparam logic [5:0] A_TSRC = 6'h00, A_TSET = 6'h04, A_TCLR = 6'h08, A_TMSK = 6'h0C;
  localparam logic [5:0] A_CSRC = 6'h10, A_CSET = 6'h14, A_CCLR = 6'h18, A_CMSK = 6'h1C;
  localparam logic [5:0] A_DSRC = 6'h20, A_DSET = 6'h24, A_DCLR = 6'h28, A_DMSK = 6'h2C;
  localparam logic [5:0] A_CFG  = 6'h30;

  logic clk = 0, rst_n = 0, power = 0, wr_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, hw_set = '0, hw_clr = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator #(.ADDR_W(6), .HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .power_i(power), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hw_set_i(hw_set), .hw_clr_i(hw_clr), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_rd(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_rd("R1 top mask", A_TMSK, 32'hFFFF_FFFF);
    chk_rd("R1 top src", A_TSRC, 0);
    chk_rd("R1 core src", A_CSRC, 0);
    chk_rd("R1 core mask", A_CMSK, 0);
    chk_rd("R1 dma src", A_DSRC, 0);
    chk_rd("R1 dma mask", A_DMSK, 0);
    chk_rd("R1 cfg", A_CFG, 0);
    chk("R1 irq", irq, 0);

    // R10 hold-off: polarity 0, nothing pending would drive high
    @(negedge clk); power = 1;
    repeat (HOLD) @(negedge clk);
    chk("R10 still held", irq, 0);
    repeat (3) @(negedge clk);
    chk("R10 released", irq, 1);
    // power cycle cut short keeps line low
    power = 0; @(negedge clk); power = 1;
    repeat (3) @(negedge clk);
    chk("R10 rise forces low", irq, 0);
    repeat (HOLD / 2) @(negedge clk); power = 0;
    repeat (3 * HOLD) @(negedge clk);
    chk("R10 aborted hold-off", irq, 0);
    power = 1;
    repeat (HOLD + 3) @(negedge clk);
    chk("R10 re-released", irq, 1);

    // R8 polarity high, unmask all top bits
    wr(A_CFG, 32'd1 << 17);
    chk_rd("R3 cfg readback", A_CFG, 32'd1 << 17);
    wr(A_TMSK, 0);
    settle();
    chk("R8 pol1 idle", irq, 0);

    // R4 core sweep
    for (int b = 0; b < 32; b++) begin
      exp = (b < 16) ? (32'd1 << 9) : (32'd1 << 8);
      wr(A_CSET, 32'd1 << b);
      settle();
      chk_rd("R2 core set", A_CSRC, 32'd1 << b);
      chk_rd("R3 core set alias", A_CSET, 32'd1 << b);
      chk_rd("R4 core summary", A_TSRC, exp);
      chk("R9 irq core", irq, 1);
      wr(A_CMSK, 32'd1 << b);
      settle();
      chk_rd("R3 core mask read", A_CMSK, 32'd1 << b);
      chk_rd("R4 masked core", A_TSRC, 0);
      chk("R8 masked core irq", irq, 0);
      wr(A_CCLR, 32'hFFFF_FFFF);
      wr(A_CMSK, 0);
      settle();
      chk_rd("R2 core clear", A_CCLR, 0);
      chk_rd("R4 core summary clear", A_TSRC, 0);
    end

    // R5 dma sweep
    for (int b = 0; b < 32; b++) begin
      wr(A_DSET, 32'd1 << b);
      settle();
      chk_rd("R5 dma summary", A_TSRC, 32'd1 << 24);
      chk("R5 dma irq", irq, 1);
      wr(A_DMSK, ~(32'd1 << b));
      settle();
      chk_rd("R5 other bits masked", A_TSRC, 32'd1 << 24);
      wr(A_DMSK, 32'd1 << b);
      settle();
      chk_rd("R5 masked dma", A_TSRC, 0);
      chk_rd("R3 dma src", A_DSRC, 32'd1 << b);
      wr(A_DCLR, 32'd1 << b);
      wr(A_DMSK, 0);
      settle();
      chk_rd("R2 dma clear", A_DSRC, 0);
    end

    // top-level direct bits, both masks and polarities
    for (int b = 0; b < 32; b++) begin
      exp = ((32'd1 << b) & SUMS) != 0 ? 32'd0 : (32'd1 << b);
      wr(A_TSET, 32'd1 << b);
      settle();
      chk_rd(exp == 0 ? "R6 summary sw set" : "R2 top set", A_TSRC, exp);
      chk("R8 pol1 top", irq, exp != 0);
      wr(A_TMSK, 32'd1 << b);
      settle();
      chk("R8 pol1 masked", irq, 0);
      wr(A_CFG, 0);
      settle();
      chk("R8 pol0 masked", irq, 1);
      wr(A_TMSK, 0);
      settle();
      chk("R8 pol0 pending", irq, exp == 0);
      wr(A_CFG, 32'd1 << 17);
      wr(A_TCLR, 32'd1 << b);
      settle();
      chk_rd("R2 top clear", A_TSRC, 0);
    end

    // R6 hardware cannot touch summary bits
    @(negedge clk); hw_set = SUMS; @(negedge clk); hw_set = 0;
    settle();
    chk_rd("R6 summary hw set", A_TSRC, 0);

    // R7 hw set wins over sw clear; hw clear clears
    wr(A_TSET, 32'h18);
    @(negedge clk); addr = A_TCLR; wdata = 32'h18; wr_en = 1; hw_set = 32'h8;
    @(negedge clk); wr_en = 0; hw_set = 0;
    settle();
    chk_rd("R7 hw set beats sw clear", A_TSRC, 32'h8);
    @(negedge clk); hw_set = 32'h1; hw_clr = 32'h9;
    @(negedge clk); hw_set = 0; hw_clr = 0;
    settle();
    chk_rd("R7 hw set beats hw clear", A_TSRC, 32'h1);
    @(negedge clk); hw_clr = 32'h1;
    @(negedge clk); hw_clr = 0;
    settle();
    chk_rd("R7 hw clear", A_TSRC, 0);

    // R11 unmapped address
    wr(6'h34, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    settle();
    chk_rd("R11 unmapped read", 6'h34, 0);
    chk_rd("R11 top intact", A_TSRC, 0);
    chk_rd("R11 top mask intact", A_TMSK, 0);
    chk_rd("R11 cfg intact", A_CFG, 32'd1 << 17);
    chk("R11 irq intact", irq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule